// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss for a 32-bit virtual address by reading a two-level page table from memory. A requester presents the 20-bit virtual page number together with the physical base address of the top-level table. The walker first reads the top-level entry. If that entry is present, it then reads the entry in the second-level table that the top-level entry points to. The walk ends with either a physical frame number or a page fault.

Only one walk runs at a time. The walker refuses new misses until it has reported a result. It talks to memory through a single read port. Requests on that port use a valid/ready handshake, and read data comes back on a separate valid strobe. The table layout is fixed:
- The upper 10 bits of the page number index the top-level table.
- The lower 10 bits index the second-level table.
- Each entry is a 32-bit word.
- Bit 0 of an entry means present.
- Bits 31:12 of an entry hold a frame number.
- An entry's address is the table base plus four times the index.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: missReady is 1, busy is 0, memReqValid is 0 and walkDone is 0.
- R2: The first read goes to rootBase + 4 * missVpn[19:10]. While memReqValid is 1 and memReqReady is 0, the request stays asserted and memReqAddr does not change.
- R3: If the top-level entry has bit 0 clear, the walk ends with walkDone=1 and walkFault=1, and the walker issues no second memory request.
- R4: The second read goes to {topEntry[31:12], 12'h000} + 4 * missVpn[9:0].
- R5: If the second-level entry has bit 0 set, the walker reports walkDone=1, walkFault=0 and walkPpn equal to bits 31:12 of that entry.
- R6: If the second-level entry has bit 0 clear, the walker reports walkDone=1 and walkFault=1, with walkPpn=0.
- R7: walkDone is high for exactly one cycle. In the next cycle the walker is idle again and missReady is 1.
- R8: While a walk is in progress, missReady is 0 and busy is 1. A miss presented during that time does not change the walk or its result.
- R9: The walker ignores memRspValid in any cycle when no read is outstanding.
- R10: The walker ignores entry bits 11:1 at both levels; they do not change the addresses or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | A translation miss is presented |
| missReady | output | 1 | The walker is idle and accepts a miss |
| missVpn | input | 20 | Virtual page number of the miss |
| rootBase | input | 32 | Physical base address of the top-level table |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts the read request |
| memReqAddr | output | 32 | Read request byte address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data (a table entry) |
| walkDone | output | 1 | One-cycle pulse: the walk result is valid |
| walkFault | output | 1 | Qualifies walkDone: the walk ended in a page fault |
| walkPpn | output | 20 | Physical frame number when walkDone is 1 and walkFault is 0 |
| busy | output | 1 | A walk is in progress |

## Verification
The walker is tried with four kinds of table content:
- a complete valid path, which tells the correct index slicing from swapped or shifted fields;
- an absent top-level entry, which shows that the walk ends without a second read;
- an absent second-level entry, which separates the two fault paths;
- entries with bits 11:1 set, read at the largest indices, which expose any use of those bits in forming an address.

Each walk pattern is run both with zero-stall, zero-latency memory and with stalled grants and delayed data. The delayed runs show whether the address is held and whether the walker waits for data instead of sampling it early. Further runs keep a second miss asserted during a walk and inject response strobes when no read is outstanding. Both must leave the result unchanged.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ_L1 = 3'd1,
    ST_WAIT_L1 = 3'd2,
    ST_READ_L2 = 3'd3,
    ST_WAIT_L2 = 3'd4,
    ST_DONE    = 3'd5,
    ST_FAULT   = 3'd6
  } walkState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureMiss;  // latch page number and root base
    logic captureL1;    // latch top-level entry
    logic captureL2;    // latch second-level entry
    logic selL2;        // drive second-level address
    logic showResult;   // present frame number on walkPpn
  } dpCtrl_t;

endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    missValid,
  input  logic    memReqReady,
  input  logic    memRspValid,
  input  logic    rspEntryValid,
  output dpCtrl_t dpCtrl,
  output logic    missReady,
  output logic    memReqValid,
  output logic    walkDone,
  output logic    walkFault,
  output logic    busy
);

  walkState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:    if (missValid)   stateD = ST_READ_L1;
      ST_READ_L1: if (memReqReady) stateD = ST_WAIT_L1;
      ST_WAIT_L1: if (memRspValid) stateD = rspEntryValid ? ST_READ_L2 : ST_FAULT;
      ST_READ_L2: if (memReqReady) stateD = ST_WAIT_L2;
      ST_WAIT_L2: if (memRspValid) stateD = rspEntryValid ? ST_DONE : ST_FAULT;
      ST_DONE:    stateD = ST_IDLE;
      ST_FAULT:   stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    dpCtrl.captureMiss = (stateQ == ST_IDLE) && missValid;
    dpCtrl.captureL1   = (stateQ == ST_WAIT_L1) && memRspValid;
    dpCtrl.captureL2   = (stateQ == ST_WAIT_L2) && memRspValid;
    dpCtrl.selL2       = (stateQ == ST_READ_L2);
    dpCtrl.showResult  = (stateQ == ST_DONE);
  end

  assign missReady   = (stateQ == ST_IDLE);
  assign busy        = (stateQ != ST_IDLE);
  assign memReqValid = (stateQ == ST_READ_L1) || (stateQ == ST_READ_L2);
  assign walkDone    = (stateQ == ST_DONE) || (stateQ == ST_FAULT);
  assign walkFault   = (stateQ == ST_FAULT);

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int PA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int IDX_W     = 10,
  parameter int PTE_W     = 32,
  parameter int VALID_BIT = 0,
  localparam int VPN_W    = 2 * IDX_W,
  localparam int PPN_W    = PA_W - OFF_W
)(
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          dpCtrl,
  input  logic [VPN_W-1:0] missVpn,
  input  logic [PA_W-1:0]  rootBase,
  input  logic [PTE_W-1:0] memRspData,
  output logic             rspEntryValid,
  output logic [PA_W-1:0]  memReqAddr,
  output logic [PPN_W-1:0] walkPpn
);

  localparam int ENT_SH = $clog2(PTE_W / 8);

  logic [VPN_W-1:0] vpnQ;
  logic [PA_W-1:0]  rootQ;
  logic [PPN_W-1:0] l1FrameQ, l2FrameQ;
  logic [IDX_W-1:0] idxHi, idxLo;
  logic [PA_W-1:0]  l1Addr, l2Base, l2Addr;
  logic             unusedEntryBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ     <= '0;
      rootQ    <= '0;
      l1FrameQ <= '0;
      l2FrameQ <= '0;
    end else begin
      if (dpCtrl.captureMiss) begin
        vpnQ  <= missVpn;
        rootQ <= rootBase;
      end
      if (dpCtrl.captureL1) l1FrameQ <= memRspData[PTE_W-1 -: PPN_W];
      if (dpCtrl.captureL2) l2FrameQ <= memRspData[PTE_W-1 -: PPN_W];
    end
  end

  assign idxHi  = vpnQ[VPN_W-1 -: IDX_W];
  assign idxLo  = vpnQ[IDX_W-1:0];
  assign l1Addr = rootQ + (PA_W'(idxHi) << ENT_SH);
  assign l2Base = {l1FrameQ, {OFF_W{1'b0}}};
  assign l2Addr = l2Base + (PA_W'(idxLo) << ENT_SH);

  assign memReqAddr      = dpCtrl.selL2 ? l2Addr : l1Addr;
  assign rspEntryValid   = memRspData[VALID_BIT];
  assign walkPpn         = dpCtrl.showResult ? l2FrameQ : '0;
  assign unusedEntryBits = ^memRspData[OFF_W-1:0];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int PA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int IDX_W     = 10,
  parameter int PTE_W     = 32,
  parameter int VALID_BIT = 0,
  localparam int VPN_W    = 2 * IDX_W,
  localparam int PPN_W    = PA_W - OFF_W
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             missValid,
  output logic             missReady,
  input  logic [VPN_W-1:0] missVpn,
  input  logic [PA_W-1:0]  rootBase,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [PTE_W-1:0] memRspData,
  output logic             walkDone,
  output logic             walkFault,
  output logic [PPN_W-1:0] walkPpn,
  output logic             busy
);

  dpCtrl_t dpCtrl;
  logic    rspEntryValid;

  pt_walker_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .missValid    (missValid),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .rspEntryValid(rspEntryValid),
    .dpCtrl       (dpCtrl),
    .missReady    (missReady),
    .memReqValid  (memReqValid),
    .walkDone     (walkDone),
    .walkFault    (walkFault),
    .busy         (busy)
  );

  pt_walker_dp #(
    .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .PTE_W(PTE_W), .VALID_BIT(VALID_BIT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .dpCtrl       (dpCtrl),
    .missVpn      (missVpn),
    .rootBase     (rootBase),
    .memRspData   (memRspData),
    .rspEntryValid(rspEntryValid),
    .memReqAddr   (memReqAddr),
    .walkPpn      (walkPpn)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W  = 32,
  parameter int PPN_W = 20
)(
  input logic             clk,
  input logic             rstN,
  input logic             missValid,
  input logic             missReady,
  input logic             busy,
  input logic             memReqValid,
  input logic             memReqReady,
  input logic [PA_W-1:0]  memReqAddr,
  input logic             walkDone,
  input logic             walkFault,
  input logic [PPN_W-1:0] walkPpn
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    missReady |-> (!memReqValid && !walkDone));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  assert_fault_ppn_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    walkFault |-> (walkDone && walkPpn == '0));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    walkDone |=> (!walkDone && missReady));

  assert_accept_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady) |=> (busy && !missReady));

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .PPN_W(PPN_W)) u_pt_walker_chk (
  .clk        (clk),
  .rstN       (rstN),
  .missValid  (missValid),
  .missReady  (missReady),
  .busy       (busy),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memReqAddr (memReqAddr),
  .walkDone   (walkDone),
  .walkFault  (walkFault),
  .walkPpn    (walkPpn)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rstN;
  logic        missValid, missReady;
  logic [19:0] missVpn;
  logic [31:0] rootBase;
  logic        memReqValid, memReqReady;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        walkDone, walkFault, busy;
  logic [19:0] walkPpn;

  always #10 clk = ~clk;  // 50 MHz

  pt_walker i_pt_walker (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missReady(missReady),
    .missVpn(missVpn), .rootBase(rootBase),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .walkDone(walkDone), .walkFault(walkFault), .walkPpn(walkPpn), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  localparam int WATCHDOG = 20000;

  logic [31:0] memImg [logic [31:0]];

  // memory model settings
  int          stallSet = 0, stallLeft = 0, latency = 0, rspWait = 0;
  bit          pend = 0, strayOn = 0;
  logic [31:0] pendAddr;

  // reference model: 0 idle,1 first read,2 first wait,3 second read,4 second wait,5 result,6 fault
  int          mPhase = 0;
  logic [19:0] mVpn;
  logic [31:0] mRoot, mE1, mE2;

  always @(posedge clk) begin
    if (!rstN) mPhase = 0;
    else begin
      case (mPhase)
        0: if (missValid) begin mVpn = missVpn; mRoot = rootBase; mE1 = '0; mE2 = '0; mPhase = 1; end
        1: if (memReqReady) mPhase = 2;
        2: if (memRspValid) begin mE1 = memRspData; mPhase = memRspData[0] ? 3 : 6; end
        3: if (memReqReady) mPhase = 4;
        4: if (memRspValid) begin mE2 = memRspData; mPhase = memRspData[0] ? 5 : 6; end
        default: mPhase = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [31:0] expAddr;
    string faultTag;
    check(missReady == (mPhase == 0), (mPhase == 0) ? "R1" : "R8", "missReady",
          {31'd0, missReady}, {31'd0, mPhase == 0});
    check(busy == (mPhase != 0), (mPhase == 0) ? "R1" : "R8", "busy",
          {31'd0, busy}, {31'd0, mPhase != 0});
    check(memReqValid == (mPhase == 1 || mPhase == 3), (mPhase == 6) ? "R3" : "R2", "memReqValid",
          {31'd0, memReqValid}, {31'd0, mPhase == 1 || mPhase == 3});
    if (mPhase == 1) begin
      expAddr = mRoot + {20'd0, mVpn[19:10], 2'b00};
      check(memReqAddr == expAddr, "R2", "first address", memReqAddr, expAddr);
    end
    if (mPhase == 3) begin
      expAddr = {mE1[31:12], 12'h000} + {20'd0, mVpn[9:0], 2'b00};
      check(memReqAddr == expAddr, "R4", "second address", memReqAddr, expAddr);
    end
    check(walkDone == (mPhase == 5 || mPhase == 6), "R7", "walkDone",
          {31'd0, walkDone}, {31'd0, mPhase == 5 || mPhase == 6});
    faultTag = mE1[0] ? "R6" : "R3";
    check(walkFault == (mPhase == 6), faultTag, "walkFault",
          {31'd0, walkFault}, {31'd0, mPhase == 6});
    check(walkPpn == ((mPhase == 5) ? mE2[31:12] : 20'd0), "R5", "walkPpn",
          {12'd0, walkPpn}, {12'd0, (mPhase == 5) ? mE2[31:12] : 20'd0});
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      finishRun();
    end
    compareAll();
    // memory responder drives the inputs for the coming edge
    memRspValid = 1'b0;
    memRspData  = '0;
    if (pend) begin
      if (rspWait == 0) begin
        memRspValid = 1'b1;
        memRspData  = memImg.exists(pendAddr) ? memImg[pendAddr] : 32'h0;
        pend = 0;
      end else rspWait--;
    end else if (strayOn && mPhase != 2 && mPhase != 4) begin
      memRspValid = 1'b1;  // stray strobe, must be ignored (R9)
      memRspData  = 32'hFFFF_FFFF;
    end
    memReqReady = 1'b0;
    if (memReqValid) begin
      if (stallLeft > 0) stallLeft--;
      else begin
        memReqReady = 1'b1;
        pend = 1; pendAddr = memReqAddr; rspWait = latency; stallLeft = stallSet;
      end
    end
  endtask

  task automatic runWalk(input logic [19:0] vpn, input logic [31:0] root,
                         input bit expFault, input logic [19:0] expPpn,
                         input string tag, input bit holdMiss);
    int guard = 0;
    stallLeft = stallSet;
    while (mPhase != 0 && guard < 300) begin step(); guard++; end
    missVpn = vpn; rootBase = root; missValid = 1'b1;
    step();
    if (holdMiss) missVpn = ~vpn;  // second miss held during the walk (R8)
    else missValid = 1'b0;
    guard = 0;
    while (!(mPhase == 5 || mPhase == 6) && guard < 300) begin step(); guard++; end
    missValid = 1'b0;
    check(walkDone === 1'b1, tag, "result pulse", {31'd0, walkDone}, 32'd1);
    check(walkFault === expFault, tag, "fault flag", {31'd0, walkFault}, {31'd0, expFault});
    check(walkPpn === (expFault ? 20'd0 : expPpn), tag, "frame number",
          {12'd0, walkPpn}, {12'd0, expFault ? 20'd0 : expPpn});
    step();
    check(!walkDone && missReady, "R7", "idle after result",
          {30'd0, walkDone, missReady}, 32'h1);
  endtask

  initial begin
    rstN = 1'b0; missValid = 1'b0; missVpn = '0; rootBase = '0;
    memReqReady = 1'b0; memRspValid = 1'b0; memRspData = '0;

    // table image
    memImg[32'h0001_000C] = 32'h0002_0001;  // top entry idx 3 -> table 0x20000
    memImg[32'h0002_0014] = 32'hABCD_E001;  // idx 5 valid
    memImg[32'h0002_0024] = 32'hABCD_E000;  // idx 9 absent
    memImg[32'h0004_0FFC] = 32'h0005_0FFF;  // junk low bits, idx 1023
    memImg[32'h0005_0FFC] = 32'h1234_5FFF;
    memImg[32'h0004_0000] = 32'h0006_0001;  // idx 0
    memImg[32'h0006_0000] = 32'h0000_1001;

    repeat (3) step();  // R1 reset state compared each cycle
    rstN = 1'b1;
    repeat (2) step();

    // R5: plain walk, fast memory
    runWalk({10'd3, 10'd5}, 32'h0001_0000, 1'b0, 20'hABCDE, "R5", 1'b0);
    // R2 R4: stalled grants and slow data
    stallSet = 3; latency = 2;
    runWalk({10'd3, 10'd5}, 32'h0001_0000, 1'b0, 20'hABCDE, "R2", 1'b0);
    // R3: absent top-level entry
    runWalk({10'd7, 10'd5}, 32'h0001_0000, 1'b1, 20'h0, "R3", 1'b0);
    stallSet = 0; latency = 0;
    runWalk({10'd7, 10'd1}, 32'h0001_0000, 1'b1, 20'h0, "R3", 1'b0);
    // R6: absent second-level entry
    runWalk({10'd3, 10'd9}, 32'h0001_0000, 1'b1, 20'h0, "R6", 1'b0);
    // R10: junk low bits, maximum indices; zero indices
    runWalk({10'd1023, 10'd1023}, 32'h0004_0000, 1'b0, 20'h12345, "R10", 1'b0);
    runWalk({10'd0, 10'd0}, 32'h0004_0000, 1'b0, 20'h00001, "R4", 1'b0);
    // R8: miss held high across the walk
    stallSet = 2; latency = 1;
    runWalk({10'd3, 10'd5}, 32'h0001_0000, 1'b0, 20'hABCDE, "R8", 1'b1);
    // R9: stray response strobes during request phases and idle
    strayOn = 1;
    runWalk({10'd1023, 10'd1023}, 32'h0004_0000, 1'b0, 20'h12345, "R9", 1'b0);
    repeat (4) step();
    check(missReady && !walkDone, "R9", "idle under stray strobes",
          {30'd0, missReady, walkDone}, 32'h2);
    strayOn = 0;
    // R7: back-to-back walks
    stallSet = 0; latency = 0;
    runWalk({10'd0, 10'd0}, 32'h0004_0000, 1'b0, 20'h00001, "R7", 1'b0);
    runWalk({10'd3, 10'd9}, 32'h0001_0000, 1'b1, 20'h0, "R7", 1'b0);

    repeat (3) step();
    finishRun();
  end

endmodule